// File: doc/BRIEF.md
# Multichannel Serial Audio Receiver

This block takes in stereo serial audio on eight independent input lanes. Every lane has its own bit clock, frame-sync and data wire. The three wires are brought into the system clock domain through two-stage synchronisers. Each bit is taken on a rising bit-clock edge, as the system clock sees that edge. A lane splits every frame into two 32-bit halves and decodes each half according to the selected format. It sends one 32-bit word per half.

Ready words from all lanes go through a round-robin arbiter into one shared FIFO, 32 data bits wide and eight entries deep. Each entry also carries the lane number and a left/right tag, so a host reading the single pop port can sort the samples. When the FIFO is full, a granted word is dropped and a sticky overflow flag is set. The host clears the flag with a one-cycle pulse.

Top module: `audio_in_port`

## Requirements
- R1: After synchronous reset, `rd_valid` and `overflow` are 0, and no word appears until a lane receives input.
- R2: `fmt` codes 2 and 3 select left-justified mode with 24 and 32 bits. Here `fsync` high marks the left half. The MSB is the bit taken on the first rising bit-clock edge at which the new `fsync` level is seen.
- R3: `fmt` codes 0 and 1 select I2S mode with 24 and 32 bits. Here `fsync` low marks the left half. The MSB comes one bit clock after the `fsync` change, and the LSB of a 32-bit half falls on the first bit clock after the next change.
- R4: `fmt` codes 4, 5, 6 and 7 select right-justified mode with 24, 20, 18 and 16 bits. Here `fsync` high marks the left half, and the LSB is the bit taken on the 32nd bit clock of the half.
- R5: Each sample is stored MSB-aligned in `rd_data`, with the unused low bits zero. A 32-bit format fills the whole word.
- R6: One `fsync` period gives exactly two FIFO entries, left then right. `rd_right` is 0 for left and 1 for right, and `rd_ch` gives the lane number 0 to 7.
- R7: When several lanes have a word ready in the same cycle, all of them are written, one per cycle. The search starts at the lane after the last one granted, and starts at lane 0 after reset. A lane keeps its word until it is granted.
- R8: The FIFO holds eight entries and shows its oldest entry on `rd_*` whenever `rd_valid` is 1. A cycle with `rd_en` high and `rd_valid` high removes that entry.
- R9: A word granted while the FIFO holds eight entries is dropped and sets `overflow`. The stored entries stay unchanged, and `overflow` stays set.
- R10: A pulse on `ovf_clr` clears `overflow`. A drop in the same cycle takes priority and keeps the flag set.
- R11: `rd_en` while the FIFO is empty has no effect, and later words are stored and read normally.
- R12: A lane whose bit clock does not toggle, or whose `fsync` has not changed since reset, produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 3 | Format and word-length code, held steady while audio runs |
| bclk | input | 8 | Bit clock, one per lane |
| fsync | input | 8 | Frame sync, one per lane |
| sdata | input | 8 | Serial data, one per lane |
| rd_en | input | 1 | Pop the head entry |
| rd_valid | output | 1 | FIFO not empty |
| rd_data | output | 32 | Head entry sample, MSB-aligned |
| rd_ch | output | 3 | Head entry lane number |
| rd_right | output | 1 | Head entry half: 0 left, 1 right |
| overflow | output | 1 | Sticky flag for a dropped word |
| ovf_clr | input | 1 | Clears `overflow` |

## Verification
Some properties are asserted on every cycle:
- the arbiter grants at most one lane, and only a requesting one;
- a pending word stays pending until it is granted;
- the FIFO level stays within its depth and moves correctly on a write or on a pop from empty;
- the overflow flag is sticky and is set by every drop.

Other behaviour can only be shown by the bench scenarios, because it depends on the serial bit order seen over a whole frame:
- the bit position of the MSB and LSB in each of the eight formats;
- MSB alignment and zero fill of the stored word;
- the left/right tag and the lane order inside each batch;
- which entries survive an overflow.

// File: rtl/audio_in_pkg.sv
package audio_in_pkg;

    localparam int WORD_W    = 32;
    localparam int HALF_BITS = 32;

    typedef enum logic [2:0] {
        FMT_I2S24 = 3'd0,
        FMT_I2S32 = 3'd1,
        FMT_LJ24  = 3'd2,
        FMT_LJ32  = 3'd3,
        FMT_RJ24  = 3'd4,
        FMT_RJ20  = 3'd5,
        FMT_RJ18  = 3'd6,
        FMT_RJ16  = 3'd7
    } fmt_t;

    typedef struct packed {
        logic              right;
        logic [WORD_W-1:0] data;
    } half_word_t;

    function automatic logic [5:0] fmt_width(input fmt_t f);
        case (f)
            FMT_I2S32, FMT_LJ32: fmt_width = 6'd32;
            FMT_RJ20:            fmt_width = 6'd20;
            FMT_RJ18:            fmt_width = 6'd18;
            FMT_RJ16:            fmt_width = 6'd16;
            default:             fmt_width = 6'd24;
        endcase
    endfunction

    function automatic logic fmt_is_i2s(input fmt_t f);
        fmt_is_i2s = (f == FMT_I2S24) || (f == FMT_I2S32);
    endfunction

    function automatic logic fmt_is_rj(input fmt_t f);
        fmt_is_rj = f[2];
    endfunction

endpackage

// File: rtl/audio_lane.sv
module audio_lane
    import audio_in_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fmt_t       fmt,
    input  logic       bclk_in,
    input  logic       fs_in,
    input  logic       sd_in,
    input  logic       gnt,
    output logic       req,
    output half_word_t word
);
    localparam logic [5:0] IDX_IDLE = 6'(HALF_BITS);
    localparam logic [5:0] IDX_LAST = 6'(HALF_BITS - 1);

    logic [2:0] bclk_sr;
    logic [1:0] fs_sr, sd_sr;
    logic       fs_last, eff_prev;
    logic [5:0] cnt;
    logic [WORD_W-1:0] sh;

    logic       rise, i2s, rj, eff, new_half, in_win, emit;
    logic [5:0] w, idx;
    logic [WORD_W-1:0] sh_next;

    always_comb begin
        rise     = bclk_sr[1] & ~bclk_sr[2];
        i2s      = fmt_is_i2s(fmt);
        rj       = fmt_is_rj(fmt);
        w        = fmt_width(fmt);
        eff      = i2s ? fs_last : fs_sr[1];
        new_half = (eff != eff_prev);
        if (new_half)
            idx = 6'd0;
        else if (cnt >= IDX_LAST)
            idx = IDX_IDLE;
        else
            idx = cnt + 6'd1;
        in_win  = rj ? ((idx >= IDX_IDLE - w) && (idx < IDX_IDLE)) : (idx < w);
        sh_next = new_half ? '0 : sh;
        if (in_win)
            sh_next = {sh_next[WORD_W-2:0], sd_sr[1]};
        emit = rise && (idx == IDX_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_sr  <= '0;
            fs_sr    <= '0;
            sd_sr    <= '0;
            fs_last  <= 1'b0;
            eff_prev <= 1'b0;
            cnt      <= IDX_IDLE;
            sh       <= '0;
            req      <= 1'b0;
            word     <= '0;
        end else begin
            bclk_sr <= {bclk_sr[1:0], bclk_in};
            fs_sr   <= {fs_sr[0], fs_in};
            sd_sr   <= {sd_sr[0], sd_in};
            if (rise) begin
                fs_last  <= fs_sr[1];
                eff_prev <= eff;
                cnt      <= idx;
                sh       <= sh_next;
            end
            if (emit) begin
                req        <= 1'b1;
                word.data  <= sh_next << (IDX_IDLE - w);
                word.right <= i2s ? eff : ~eff;
            end else if (gnt) begin
                req <= 1'b0;
            end
        end
    end

    // R7: a word waits in its lane until the arbiter takes it
    a_r7_pending_held: assert property (@(posedge clk) disable iff (rst)
        (req && !gnt) |=> req);

endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic [CW-1:0] ptr;
    logic [CW-1:0] win;
    logic          found;

    always_comb begin
        gnt   = '0;
        win   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            int k;
            k = int'(ptr) + i;
            if (k >= N) k = k - N;
            if (!found && req[k]) begin
                found  = 1'b1;
                gnt[k] = 1'b1;
                win    = CW'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (found)
            ptr <= (int'(win) == N - 1) ? '0 : win + CW'(1);
    end

    // R7: at most one grant, and only to a requester
    a_r7_onehot_grant:   assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
    a_r7_grant_needs_req: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0);

endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int W     = 36,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign dout    = mem[rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (int'(wp) == DEPTH - 1) ? '0 : wp + AW'(1);
            end
            if (do_pop)
                rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + AW'(1);
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

    // R8: level bounded and tracks writes
    a_r8_level_bound: assert property (@(posedge clk) disable iff (rst)
        count <= (AW+1)'(DEPTH));
    a_r8_push_counts: assert property (@(posedge clk) disable iff (rst)
        (do_push && !pop) |=> count == $past(count) + 1'b1);
    // R11: a pop on empty leaves the FIFO empty
    a_r11_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (empty && !push) |=> empty);

endmodule

// File: rtl/audio_in_port.sv
module audio_in_port
    import audio_in_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        fmt,
    input  logic [NUM_CH-1:0] bclk,
    input  logic [NUM_CH-1:0] fsync,
    input  logic [NUM_CH-1:0] sdata,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic [2:0]        rd_ch,
    output logic              rd_right,
    output logic              overflow,
    input  logic              ovf_clr
);
    localparam int CH_W    = 3;
    localparam int ENTRY_W = CH_W + 1 + WORD_W;

    fmt_t              fmt_q;
    logic [NUM_CH-1:0] req, gnt;
    half_word_t        lane_word [NUM_CH];
    half_word_t        sel_word;
    logic [CH_W-1:0]   sel_ch;
    logic              any_gnt, fifo_empty, fifo_full;
    logic [ENTRY_W-1:0] fifo_out;

    assign fmt_q = fmt_t'(fmt);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        audio_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .fmt     (fmt_q),
            .bclk_in (bclk[c]),
            .fs_in   (fsync[c]),
            .sd_in   (sdata[c]),
            .gnt     (gnt[c]),
            .req     (req[c]),
            .word    (lane_word[c])
        );
    end

    rr_arbiter #(.N(NUM_CH)) u_arb (
        .clk (clk),
        .rst (rst),
        .req (req),
        .gnt (gnt)
    );

    always_comb begin
        sel_word = '0;
        sel_ch   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (gnt[i]) begin
                sel_word = lane_word[i];
                sel_ch   = CH_W'(i);
            end
        end
        any_gnt = |gnt;
    end

    word_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (any_gnt),
        .din   ({sel_ch, sel_word}),
        .pop   (rd_en),
        .dout  (fifo_out),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assign rd_valid = !fifo_empty;
    assign {rd_ch, rd_right, rd_data} = fifo_out;

    always_ff @(posedge clk) begin
        if (rst)
            overflow <= 1'b0;
        else if (any_gnt && fifo_full)
            overflow <= 1'b1;
        else if (ovf_clr)
            overflow <= 1'b0;
    end

    // R9: every drop raises the flag, which then holds
    a_r9_ovf_on_drop: assert property (@(posedge clk) disable iff (rst)
        (any_gnt && fifo_full) |=> overflow);
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clr) |=> overflow);
    // R1: nothing stored right after reset
    a_r1_reset_empty: assert property (@(posedge clk)
        $fell(rst) |-> !rd_valid && !overflow);

endmodule

// File: tb/test_audio_in_port.sv
module test_audio_in_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fmt = 3'd0;
    logic [7:0]  bclk = '0, fsync = '0, sdata = '0;
    logic        rd_en;
    logic        rd_valid, rd_right, overflow;
    logic [31:0] rd_data;
    logic [2:0]  rd_ch;
    logic        ovf_clr = 1'b0;

    int n_tests = 0, n_fail = 0;
    logic [31:0] smp [8][4];
    logic [31:0] got_d [64];
    logic [2:0]  got_c [64];
    logic        got_r [64];
    int          ncol = 0;
    int          rr_ptr = 0;
    logic        auto_pop = 1'b0, force_pop = 1'b0;
    int          seed_sink;

    always #10 clk = ~clk;

    audio_in_port i_audio_in_port (
        .clk(clk), .rst(rst), .fmt(fmt), .bclk(bclk), .fsync(fsync), .sdata(sdata),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ch(rd_ch),
        .rd_right(rd_right), .overflow(overflow), .ovf_clr(ovf_clr)
    );

    assign rd_en = force_pop || (auto_pop && rd_valid);

    always @(negedge clk) begin
        if (auto_pop && rd_valid && ncol < 64) begin
            got_d[ncol] = rd_data;
            got_c[ncol] = rd_ch;
            got_r[ncol] = rd_right;
            ncol = ncol + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int width_of(input int f);
        case (f)
            1, 3: return 32;
            5: return 20;
            6: return 18;
            7: return 16;
            default: return 24;
        endcase
    endfunction

    function automatic logic [31:0] expect_word(input logic [31:0] s, input int w);
        logic [31:0] m;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        return (s & m) << (32 - w);
    endfunction

    function automatic string tag_of(input int f);
        if (f < 2) return "R3";
        if (f < 4) return "R2";
        return "R4";
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        bclk = '0; fsync = '0; sdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rr_ptr = 0;
        ncol = 0;
    endtask

    task automatic pulse_bclk(input logic [7:0] mask);
        repeat (4) @(negedge clk);
        bclk = mask;
        repeat (4) @(negedge clk);
        bclk = '0;
    endtask

    task automatic send(input int f, input logic [7:0] mask, input int nfr);
        int  w;
        bit  i2s, rj;
        logic left_lvl;
        w = width_of(f);
        i2s = (f < 2);
        rj = (f >= 4);
        left_lvl = i2s ? 1'b0 : 1'b1;
        fmt = 3'(f);
        for (int c = 0; c < 8; c++)
            for (int h = 0; h < 2 * nfr; h++)
                smp[c][h] = $urandom;
        smp[0][0] = 32'hFFFF_FFFF;
        smp[1][0] = 32'h0000_0001;
        for (int k = 0; k < 4; k++) begin
            fsync = {8{~left_lvl}};
            sdata = '0;
            pulse_bclk(mask);
        end
        for (int t = 0; t < 64 * nfr + 2; t++) begin
            int h, s;
            logic lvl;
            h = t / 32;
            lvl = (h < 2 * nfr) ? ((h % 2 == 0) ? left_lvl : ~left_lvl) : left_lvl;
            s = i2s ? t - 1 : t;
            for (int c = 0; c < 8; c++) begin
                logic b;
                b = 1'b0;
                if (s >= 0 && s < 64 * nfr) begin
                    int hs, j;
                    hs = s / 32;
                    j = s % 32;
                    if (rj ? (j >= 32 - w) : (j < w))
                        b = smp[c][hs][rj ? 31 - j : w - 1 - j];
                end
                sdata[c] = b;
            end
            fsync = {8{lvl}};
            pulse_bclk(mask);
        end
        repeat (30) @(negedge clk);
    endtask

    // Compares collected words against the round-robin model, halves h0..h0+nh-1
    task automatic check_got(input int f, input logic [7:0] mask, input int h0, input int nh);
        int n;
        n = 0;
        for (int h = h0; h < h0 + nh; h++) begin
            int last;
            last = rr_ptr;
            for (int k = 0; k < 8; k++) begin
                int c;
                c = (rr_ptr + k) % 8;
                if (mask[c]) begin
                    if (n < ncol) begin
                        check({tag_of(f), "/R5 data"}, 64'(got_d[n]), 64'(expect_word(smp[c][h], width_of(f))));
                        check("R7 lane order", 64'(got_c[n]), 64'(c));
                        check("R6 left/right tag", 64'(got_r[n]), 64'(h % 2));
                    end
                    n++;
                    last = c;
                end
            end
            rr_ptr = (last + 1) % 8;
        end
        check("R6 entry count", 64'(ncol), 64'(n));
    endtask

    initial begin
        seed_sink = $urandom(32'h5EED);
        do_reset();
        @(negedge clk);
        check("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
        check("R1 overflow after reset", 64'(overflow), 64'd0);

        // R12: fsync never changes, and no word appears
        fmt = 3'd3;
        fsync = '0;
        for (int k = 0; k < 40; k++) begin
            sdata = 8'($urandom);
            pulse_bclk(8'hFF);
        end
        repeat (10) @(negedge clk);
        check("R12 no word without fsync change", 64'(rd_valid), 64'd0);

        // R2, R3, R4, R5, R6, R7, R8: every format, two frames
        for (int f = 0; f < 8; f++) begin
            logic [7:0] m;
            m = (f == 5) ? 8'b1010_0101 : 8'hFF;
            do_reset();
            auto_pop = 1'b1;
            send(f, m, 2);
            auto_pop = 1'b0;
            check_got(f, m, 0, 4);
            check("R9 no overflow while draining", 64'(overflow), 64'd0);
        end

        // R9: no pops for one frame, so the right half overflows
        do_reset();
        send(3, 8'hFF, 1);
        check("R9 overflow set on drop", 64'(overflow), 64'd1);
        auto_pop = 1'b1;
        repeat (20) @(negedge clk);
        auto_pop = 1'b0;
        check_got(3, 8'hFF, 0, 1);
        rr_ptr = 0;
        check("R9 overflow stays set", 64'(overflow), 64'd1);

        // R11: pop on empty FIFO
        force_pop = 1'b1;
        @(negedge clk);
        force_pop = 1'b0;
        @(negedge clk);
        check("R11 still empty after pop on empty", 64'(rd_valid), 64'd0);

        // R10: clear the flag
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        @(negedge clk);
        check("R10 overflow cleared", 64'(overflow), 64'd0);

        // R11: normal traffic after pop on empty, without reset
        ncol = 0;
        auto_pop = 1'b1;
        send(3, 8'hFF, 1);
        auto_pop = 1'b0;
        check_got(3, 8'hFF, 0, 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule